// File: doc/BRIEF.md
# Packed Lane Logical Right Shifter

This block shifts a 128-bit packed vector logically to the right. The vector is split into equal lanes of 16, 32 or 64 bits, chosen by a mode input. Every lane moves right by one common amount and fills its vacated upper bits with zeros. No bit passes from one lane into its neighbour.

The shift amount comes from one of two places. In register-count mode it is the whole low 64-bit half of a second 128-bit operand. In immediate mode it is an 8-bit immediate, zero-extended. An amount equal to or larger than the lane width clears every lane. This holds even when only high-order bits of the amount are set.

The amount and the data are both captured at the clock edge that accepts the input strobe. The result is registered at that same edge and shows up with a valid flag one cycle later. Because of this, a destination that is the same register as the count source still gets the original amount in every lane.

Top module: `vec_lane_rshift`

## Requirements
- R1: With laneMode = 2'b00 the vector is eight 16-bit lanes; each lane shifts right by the amount, with zero fill and no bits crossing into a neighbouring lane.
- R2: With laneMode = 2'b01 the vector is four 32-bit lanes, shifted the same way.
- R3: With laneMode = 2'b10 or 2'b11 the vector is two 64-bit lanes, shifted the same way.
- R4: With immMode = 0 the amount is countSrc[63:0], taken as one unsigned 64-bit number; countSrc[127:64] has no effect on the result.
- R5: With immMode = 1 the amount is imm8 zero-extended, and countSrc has no effect on the result.
- R6: An amount greater than or equal to the lane width makes every lane of the result zero, whichever bits of the amount are set.
- R7: When inValid is high at a rising edge, outValid is high after that edge and dataOut holds the result computed from the inputs sampled at that edge. This still holds when countSrc carries the same value as dataIn.
- R8: When inValid is low at a rising edge, outValid is low after that edge and dataOut keeps its previous value.
- R9: A synchronous active-high reset clears outValid and dataOut to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Input strobe: accept operands this cycle |
| laneMode | input | 2 | Lane width: 00 = 16, 01 = 32, 10/11 = 64 |
| immMode | input | 1 | 1 = amount from imm8, 0 = amount from countSrc[63:0] |
| dataIn | input | 128 | Packed vector to shift |
| countSrc | input | 128 | Operand whose low 64 bits give the amount |
| imm8 | input | 8 | Immediate amount |
| outValid | output | 1 | Result valid, one cycle after inValid |
| dataOut | output | 128 | Registered shifted vector |

## Verification
The hardest case to reach is an amount whose low six bits look like a small legal shift while some far higher bit is set. In that case the result must still be all zeros. Random 64-bit counts almost always exceed every lane width, and small random counts never set high bits. The stimulus therefore mixes directed amounts (zero, width minus one, the width itself, and a value with only bit 40 set) with random draws. Those random draws are either below 80, or a small value with one random high bit added. The aliasing case is driven by putting the same value on dataIn and countSrc.

// File: rtl/vrs_pkg.sv
package vrs_pkg;

  typedef enum logic [1:0] {
    LANE16    = 2'b00,
    LANE32    = 2'b01,
    LANE64    = 2'b10,
    LANE64ALT = 2'b11
  } laneMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic      load;   // capture a new result
    logic      clear;  // amount out of range: result is zero
    laneMode_e mode;
    logic [5:0] shAmt; // amount, valid when clear is low
  } shStrobe_t;

endpackage

// File: rtl/vrs_ctrl.sv
module vrs_ctrl
  import vrs_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int CNT_W = 64,
  parameter int IMM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  laneMode_e        laneMode,
  input  logic             immMode,
  input  logic [VEC_W-1:0] countSrc,
  input  logic [IMM_W-1:0] imm8,
  output shStrobe_t        strb
);

  logic [CNT_W-1:0] effCount;
  logic [CNT_W-1:0] laneWidth;

  always_comb begin
    effCount = immMode ? CNT_W'(imm8) : countSrc[CNT_W-1:0];
    case (laneMode)
      LANE16:  laneWidth = CNT_W'(16);
      LANE32:  laneWidth = CNT_W'(32);
      default: laneWidth = CNT_W'(64);
    endcase
    strb.load  = inValid;
    strb.mode  = laneMode;
    strb.clear = (effCount >= laneWidth);
    strb.shAmt = effCount[5:0];
  end

  // R6
  hi_count_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (!immMode && (countSrc[CNT_W-1:32] != '0)) |-> strb.clear);

  // R4
  upper_half_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (!immMode && (countSrc[VEC_W-1:CNT_W] != '0) && (countSrc[CNT_W-1:0] == '0)) |-> !strb.clear);

  // R5
  imm_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    (immMode && (laneMode == LANE64) && (imm8 < 8'd64)) |-> !strb.clear);

endmodule

// File: rtl/vrs_datapath.sv
module vrs_datapath
  import vrs_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  shStrobe_t        strb,
  input  logic [VEC_W-1:0] dataIn,
  output logic             outValid,
  output logic [VEC_W-1:0] dataOut
);

  localparam int N16 = VEC_W / 16;
  localparam int N32 = VEC_W / 32;
  localparam int N64 = VEC_W / 64;

  logic [VEC_W-1:0] res16, res32, res64, selRes, nextRes;

  for (genvar g = 0; g < N16; g++) begin : gLane16
    assign res16[g*16 +: 16] = dataIn[g*16 +: 16] >> strb.shAmt[3:0];
  end
  for (genvar g = 0; g < N32; g++) begin : gLane32
    assign res32[g*32 +: 32] = dataIn[g*32 +: 32] >> strb.shAmt[4:0];
  end
  for (genvar g = 0; g < N64; g++) begin : gLane64
    assign res64[g*64 +: 64] = dataIn[g*64 +: 64] >> strb.shAmt[5:0];
  end

  always_comb begin
    case (strb.mode)
      LANE16:  selRes = res16;
      LANE32:  selRes = res32;
      default: selRes = res64;
    endcase
    nextRes = strb.clear ? '0 : selRes;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      dataOut  <= '0;
    end else begin
      outValid <= strb.load;
      if (strb.load) dataOut <= nextRes;
    end
  end

  // R7
  valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    strb.load |=> outValid);

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.load |=> (!outValid && $stable(dataOut)));

  // R6
  clear_gives_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.load && strb.clear) |=> (dataOut == '0));

  // R1
  zero_shift_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.load && !strb.clear && (strb.shAmt == 6'd0)) |=> (dataOut == $past(dataIn)));

endmodule

// File: rtl/vec_lane_rshift.sv
module vec_lane_rshift
  import vrs_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int CNT_W = 64,
  parameter int IMM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [1:0]       laneMode,
  input  logic             immMode,
  input  logic [VEC_W-1:0] dataIn,
  input  logic [VEC_W-1:0] countSrc,
  input  logic [IMM_W-1:0] imm8,
  output logic             outValid,
  output logic [VEC_W-1:0] dataOut
);

  shStrobe_t strb;

  vrs_ctrl #(.VEC_W(VEC_W), .CNT_W(CNT_W), .IMM_W(IMM_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .laneMode (laneMode_e'(laneMode)),
    .immMode  (immMode),
    .countSrc (countSrc),
    .imm8     (imm8),
    .strb     (strb)
  );

  vrs_datapath #(.VEC_W(VEC_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .dataIn   (dataIn),
    .outValid (outValid),
    .dataOut  (dataOut)
  );

endmodule

// File: tb/vec_lane_rshift_bench.sv
`timescale 1ns/1ps
module vec_lane_rshift_bench;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic [1:0]   laneMode = 2'b00;
  logic         immMode = 1'b0;
  logic [127:0] dataIn = '0;
  logic [127:0] countSrc = '0;
  logic [7:0]   imm8 = '0;
  logic         outValid;
  logic [127:0] dataOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  vec_lane_rshift u_vec_lane_rshift (
    .clk(clk), .rst(rst), .inValid(inValid), .laneMode(laneMode),
    .immMode(immMode), .dataIn(dataIn), .countSrc(countSrc), .imm8(imm8),
    .outValid(outValid), .dataOut(dataOut)
  );

  function automatic int laneBits(input logic [1:0] m);
    return (m == 2'b00) ? 16 : (m == 2'b01) ? 32 : 64;
  endfunction

  // Bitwise reference: output bit i takes the bit 'amount' places above it in the same lane
  function automatic logic [127:0] refShift(input logic [127:0] d, input logic [1:0] m,
                                            input logic im, input logic [7:0] iv,
                                            input logic [127:0] cs);
    logic [127:0] r;
    logic [63:0] amt;
    int lw;
    lw  = laneBits(m);
    amt = im ? {56'd0, iv} : cs[63:0];
    r = '0;
    for (int i = 0; i < 128; i++) begin
      int pos;
      pos = i % lw;
      if (amt < 64'(lw) && (pos + int'(amt[6:0])) < lw)
        r[i] = d[i + int'(amt[6:0])];
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string modeTag(input logic [1:0] m);
    return (m == 2'b00) ? "R1" : (m == 2'b01) ? "R2" : "R3";
  endfunction

  // Issue one op at a negedge, check at the following negedge
  task automatic runOp(input logic [1:0] m, input logic im, input logic [7:0] iv,
                       input logic [127:0] d, input logic [127:0] cs, input string tag);
    logic [127:0] exp;
    exp = refShift(d, m, im, iv, cs);
    @(negedge clk);
    inValid = 1'b1; laneMode = m; immMode = im; imm8 = iv; dataIn = d; countSrc = cs;
    @(negedge clk);
    inValid = 1'b0;
    check(outValid == 1'b1, {tag, " R7 outValid"}, {127'd0, outValid}, 128'd1);
    check(dataOut == exp, tag, dataOut, exp);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] held;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    check(outValid == 1'b0, "R9 outValid", {127'd0, outValid}, 128'd0);
    check(dataOut == '0, "R9 dataOut", dataOut, '0);
    rst = 1'b0;

    // Directed corner amounts in every mode
    for (int mi = 0; mi < 4; mi++) begin
      logic [1:0] m;
      logic [127:0] d;
      int lw;
      m  = 2'(mi);
      lw = laneBits(m);
      d  = rnd128();
      runOp(m, 1'b0, 8'd0, d, 128'd0, {modeTag(m), " amt=0"});
      runOp(m, 1'b0, 8'd0, d, 128'(lw - 1), {modeTag(m), " amt=w-1"});
      runOp(m, 1'b0, 8'd0, d, 128'(lw), {modeTag(m), " R6 amt=w"});
      runOp(m, 1'b0, 8'd0, d, 128'(1) << 40, {modeTag(m), " R6 bit40"});
      runOp(m, 1'b1, 8'(lw - 1), d, rnd128(), {modeTag(m), " R5 imm=w-1"});
      runOp(m, 1'b1, 8'd255, d, 128'd0, {modeTag(m), " R5 R6 imm=255"});
      runOp(m, 1'b0, 8'd0, d, {64'hFFFF_FFFF_FFFF_FFFF, 64'd3}, {modeTag(m), " R4 upper ignored"});
      runOp(m, 1'b0, 8'd0, d, {64'd0, 64'h8000_0000_0000_0001}, {modeTag(m), " R6 msb set"});
    end

    // Lane boundary: all-ones in, shift 1 must clear each lane's top bit only
    runOp(2'b00, 1'b1, 8'd1, {128{1'b1}}, '0, "R1 boundary");
    runOp(2'b01, 1'b1, 8'd1, {128{1'b1}}, '0, "R2 boundary");
    runOp(2'b10, 1'b1, 8'd1, {128{1'b1}}, '0, "R3 boundary");

    // Aliasing: count source carries the same value as the data
    runOp(2'b00, 1'b0, 8'd0, {64'hDEAD_BEEF_0123_4567, 64'd5}, {64'hDEAD_BEEF_0123_4567, 64'd5}, "R7 alias");
    runOp(2'b10, 1'b0, 8'd0, {64'h0F0F_0F0F_0F0F_0F0F, 64'd33}, {64'h0F0F_0F0F_0F0F_0F0F, 64'd33}, "R7 alias64");

    // Idle cycle: output holds while inputs change
    held = dataOut;
    @(negedge clk);
    inValid = 1'b0; dataIn = rnd128(); countSrc = '0; laneMode = 2'b00;
    @(negedge clk);
    check(outValid == 1'b0, "R8 outValid", {127'd0, outValid}, 128'd0);
    check(dataOut == held, "R8 hold", dataOut, held);

    // Random mix
    for (int k = 0; k < 300; k++) begin
      logic [127:0] cs;
      logic [1:0] m;
      logic im;
      m  = 2'($urandom_range(0, 3));
      im = 1'($urandom_range(0, 1));
      cs = rnd128();
      cs[63:0] = 64'($urandom_range(0, 79));
      if ($urandom_range(0, 3) == 0) cs[63:0] = cs[63:0] | (64'd1 << $urandom_range(6, 63));
      runOp(m, im, 8'($urandom), rnd128(), cs, {modeTag(m), " R4 R5 R6 random"});
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule